// File: doc/BRIEF.md
# Signed Row-Gated Tree Multiplier

This block multiplies two N-bit two's-complement operands and delivers the exact 2N-bit signed product. Each operand's top bit carries weight -2^(N-1) and every other bit carries its usual positive weight. The product is rewritten as a set of rows. Each row is the low N-1 bits of one operand, shifted, and kept only when a single bit of the other operand is 1.

Rows that add to the product form a positive group: one row for each low bit of Y, plus the product of the two sign bits at weight 2^(2N-2). Rows that subtract form a negative group of two: X's sign bit gating Y's low bits, and Y's sign bit gating X's low bits, both at weight 2^(N-1). The positive group is summed by a balanced binary adder tree. Where the row count is not a power of two, the odd node at a level passes straight through. The negative pair is summed at the same time as the first positive level. A final subtractor forms the difference and loads the product register.

A caller raises `in_vld` for one cycle with `x_in` and `y_in`. After the fixed latency it sees `out_vld` high for one cycle, with the product on `product`. Parameter `FOLD_TOP` chooses how the sign-bit term is placed. With the default of 1 it is merged into the first positive row, which keeps the row count one lower. With 0 it is kept as a row of its own, the sign-extended arrangement. Parameter `PIPE` puts a register after every tree level.

Top module: `sgn_tree_mul`

## Requirements
- R1: When `out_vld` is 1, `product`, read as a 2N-bit two's-complement value, equals the exact product of the signed `x_in` and `y_in` that were accepted with the matching `in_vld`. This includes (-2^(N-1)) times (-2^(N-1)).
- R2: Let P be the positive row count: N-1 when `FOLD_TOP`=1 and N when `FOLD_TOP`=0. With `PIPE`=1 a sample accepted at a rising edge appears ceil(log2(P))+1 edges later. With `PIPE`=0 it appears one edge later. For example, N=4 fold gives 3, N=16 fold gives 5, and N=8 unfolded unpipelined gives 1.
- R3: `out_vld` is 1 for exactly one cycle for each cycle in which `in_vld` was 1, after the R2 latency. It is 0 in every other cycle.
- R4: While `out_vld` is 0, `product` keeps the last product delivered.
- R5: While `rst` is high, and on the first cycle after it falls, `out_vld` is 0 and `product` is 0.
- R6: `FOLD_TOP`=0 yields the same products as `FOLD_TOP`=1. Only the row count P, and through it the R2 latency, changes.
- R7: The positive-group sum and the negative-group sum each stay below 2^(2N-1), so neither overflows the 2N-bit datapath. This includes the most-negative operand cases.
- R8: Operand values presented while `in_vld` is 0 do not change `product` or `out_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operands are valid this cycle |
| x_in | input | N | Signed operand X |
| y_in | input | N | Signed operand Y |
| out_vld | output | 1 | Product is valid this cycle |
| product | output | 2N | Signed product X*Y |

## Verification
The range assertions assume that only the top bit of each operand is negative-weighted, so every gated row is non-negative and both group sums are bounded. The bench guarantees this by driving any N-bit pattern, since each one is a legal operand. The alignment and hold assertions assume that the caller keeps `rst` high for at least one clock before use. The stimulus asserts reset for several cycles and keeps `in_vld` low throughout. Random operands are also driven while `in_vld` is low, so the hold property is exercised on inputs that move.

// File: rtl/tmul_pkg.sv
package tmul_pkg;
    // smallest r with 2**r >= v
    function automatic int ceil_log2(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    // node count at a given tree level for a given leaf count
    function automatic int level_count(input int leaves, input int lvl);
        return (leaves + (1 << lvl) - 1) >> lvl;
    endfunction
endpackage

// File: rtl/tmul_rows.sv
module tmul_rows #(
    parameter int N        = 8,
    parameter int FOLD_TOP = 1,
    parameter int P        = N - 1
) (
    input  logic [N-1:0]            x,
    input  logic [N-1:0]            y,
    output logic [P-1:0][2*N-1:0]   pos_row,
    output logic [1:0][2*N-1:0]     neg_row
);
    localparam int W = 2 * N;

    logic [W-1:0] top_term;
    assign top_term = W'(x[N-1] & y[N-1]) << (W - 2);

    // positive rows: low bits of x gated by each low bit of y
    for (genvar gi = 0; gi < N - 1; gi++) begin : g_pos
        logic [W-1:0] base;
        assign base = W'(x[N-2:0] & {(N-1){y[gi]}}) << gi;
        if (gi == 0 && FOLD_TOP != 0) begin : g_fold
            // top term occupies bit W-2, clear of row 0 bits
            assign pos_row[gi] = base | top_term;
        end else begin : g_plain
            assign pos_row[gi] = base;
        end
    end

    if (FOLD_TOP == 0) begin : g_top_row
        assign pos_row[N-1] = top_term;
    end

    // negative rows: one sign bit gating the other operand's low bits
    assign neg_row[0] = W'(y[N-2:0] & {(N-1){x[N-1]}}) << (N - 1);
    assign neg_row[1] = W'(x[N-2:0] & {(N-1){y[N-1]}}) << (N - 1);
endmodule

// File: rtl/tmul_tree.sv
module tmul_tree
    import tmul_pkg::*;
#(
    parameter int W      = 16,
    parameter int LEAVES = 7,
    parameter int PIPE   = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_vld,
    input  logic [LEAVES-1:0][W-1:0] leaf,
    output logic                    out_vld,
    output logic [W-1:0]            sum
);
    localparam int DEPTH = ceil_log2(LEAVES);

    if (DEPTH == 0) begin : g_single
        assign sum     = leaf[0];
        assign out_vld = in_vld;
    end else begin : g_tree
        for (genvar gl = 0; gl <= DEPTH; gl++) begin : lvl
            localparam int CNT = level_count(LEAVES, gl);
            logic [CNT-1:0][W-1:0] node;
            logic                  vld;

            if (gl == 0) begin : g_in
                assign node = leaf;
                assign vld  = in_vld;
            end else begin : g_add
                localparam int PREV = level_count(LEAVES, gl - 1);
                logic [CNT-1:0][W-1:0] comb_n;

                for (genvar gk = 0; gk < CNT; gk++) begin : g_node
                    if (2 * gk + 1 < PREV) begin : g_pair
                        assign comb_n[gk] = lvl[gl-1].node[2*gk] + lvl[gl-1].node[2*gk+1];
                    end else begin : g_pass
                        // pruned branch: odd node rides to the next level
                        assign comb_n[gk] = lvl[gl-1].node[2*gk];
                    end
                end

                if (PIPE != 0) begin : g_reg
                    always_ff @(posedge clk) begin
                        if (rst) begin
                            node <= '0;
                            vld  <= 1'b0;
                        end else begin
                            node <= comb_n;
                            vld  <= lvl[gl-1].vld;
                        end
                    end
                end else begin : g_wire
                    assign node = comb_n;
                    assign vld  = lvl[gl-1].vld;
                end
            end
        end

        assign sum     = lvl[DEPTH].node[0];
        assign out_vld = lvl[DEPTH].vld;
    end
endmodule

// File: rtl/tmul_delay.sv
module tmul_delay #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);
    if (STAGES == 0) begin : g_none
        assign out_vld  = in_vld;
        assign out_data = in_data;
    end else begin : g_line
        for (genvar gs = 0; gs < STAGES; gs++) begin : g_st
            logic [W-1:0] q;
            logic         v;
            if (gs == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= '0;
                        v <= 1'b0;
                    end else begin
                        q <= in_data;
                        v <= in_vld;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= '0;
                        v <= 1'b0;
                    end else begin
                        q <= g_st[gs-1].q;
                        v <= g_st[gs-1].v;
                    end
                end
            end
        end
        assign out_vld  = g_st[STAGES-1].v;
        assign out_data = g_st[STAGES-1].q;
    end
endmodule

// File: rtl/sgn_tree_mul.sv
module sgn_tree_mul
    import tmul_pkg::*;
#(
    parameter int N        = 8,
    parameter int FOLD_TOP = 1,
    parameter int PIPE     = 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_vld,
    input  logic [N-1:0]   x_in,
    input  logic [N-1:0]   y_in,
    output logic           out_vld,
    output logic [2*N-1:0] product
);
    localparam int W        = 2 * N;
    localparam int P        = (FOLD_TOP != 0) ? N - 1 : N;
    localparam int DP       = ceil_log2(P);
    localparam int NEG_WAIT = (PIPE != 0) ? DP - 1 : 0;

    if (N < 3) begin : g_bad_width
        $error("sgn_tree_mul needs N >= 3");
    end

    logic [P-1:0][W-1:0] pos_row;
    logic [1:0][W-1:0]   neg_row;
    logic [W-1:0]        pos_sum, neg_sum, neg_sum_d;
    logic                pos_vld, neg_vld, neg_vld_d;

    tmul_rows #(.N(N), .FOLD_TOP(FOLD_TOP), .P(P)) u_rows (
        .x(x_in), .y(y_in), .pos_row(pos_row), .neg_row(neg_row)
    );

    tmul_tree #(.W(W), .LEAVES(P), .PIPE(PIPE)) u_pos_tree (
        .clk(clk), .rst(rst), .in_vld(in_vld), .leaf(pos_row),
        .out_vld(pos_vld), .sum(pos_sum)
    );

    tmul_tree #(.W(W), .LEAVES(2), .PIPE(PIPE)) u_neg_tree (
        .clk(clk), .rst(rst), .in_vld(in_vld), .leaf(neg_row),
        .out_vld(neg_vld), .sum(neg_sum)
    );

    // negative pair finishes after one level; hold it until the positive tree catches up
    tmul_delay #(.W(W), .STAGES(NEG_WAIT)) u_neg_wait (
        .clk(clk), .rst(rst), .in_vld(neg_vld), .in_data(neg_sum),
        .out_vld(neg_vld_d), .out_data(neg_sum_d)
    );

    // final node: positive group minus negative group, registered
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            product <= '0;
        end else begin
            out_vld <= pos_vld;
            if (pos_vld) product <= pos_sum - neg_sum_d;
        end
    end

    assert_pos_range_R7: assert property (@(posedge clk) disable iff (rst)
        pos_vld |-> !pos_sum[W-1]);

    assert_neg_range_R7: assert property (@(posedge clk) disable iff (rst)
        neg_vld_d |-> !neg_sum_d[W-1]);

    assert_groups_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        pos_vld == neg_vld_d);

    assert_hold_product_R4: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> $stable(product));

    assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_vld && product == '0));
endmodule

// File: tb/sim_sgn_tree_mul.sv
`timescale 1ns/1ps
module sim_sgn_tree_mul;
    typedef struct {
        bit     v;
        longint p;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // u0: N=4 folded pipelined, latency 3 (R2)
    logic        v0 = 1'b0;
    logic [3:0]  xa0 = '0, yb0 = '0;
    logic        ov0;
    logic [7:0]  pr0;
    // u1: N=8 unfolded, no pipeline, latency 1 (R2, R6)
    logic        v1 = 1'b0;
    logic [7:0]  xa1 = '0, yb1 = '0;
    logic        ov1;
    logic [15:0] pr1;
    // u2: N=16 folded pipelined, latency 5 (R2)
    logic        v2 = 1'b0;
    logic [15:0] xa2 = '0, yb2 = '0;
    logic        ov2;
    logic [31:0] pr2;

    sgn_tree_mul #(.N(4), .FOLD_TOP(1), .PIPE(1)) u0 (
        .clk(clk), .rst(rst), .in_vld(v0), .x_in(xa0), .y_in(yb0),
        .out_vld(ov0), .product(pr0));
    sgn_tree_mul #(.N(8), .FOLD_TOP(0), .PIPE(0)) u1 (
        .clk(clk), .rst(rst), .in_vld(v1), .x_in(xa1), .y_in(yb1),
        .out_vld(ov1), .product(pr1));
    sgn_tree_mul #(.N(16), .FOLD_TOP(1), .PIPE(1)) u2 (
        .clk(clk), .rst(rst), .in_vld(v2), .x_in(xa2), .y_in(yb2),
        .out_vld(ov2), .product(pr2));

    int     errors = 0;
    int     checks = 0;
    bit     done   = 0;
    exp_t   q0[$], q1[$], q2[$];
    longint hold0 = 0, hold1 = 0, hold2 = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare one instance against its model entry; preq names the product requirement
    task automatic compare(input string tag, input string preq, input exp_t e, input bit ov,
                           input longint prod, inout longint hold);
        if (e.v) begin
            check("R2", {tag, " out_vld timing"}, longint'(ov), 1);
            check(preq, {tag, " product"}, prod, e.p);
            hold = e.p;
        end else begin
            check("R3", {tag, " out_vld idle"}, longint'(ov), 0);
            check("R4", {tag, " held product"}, prod, hold);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int k0;
        exp_t e;
        k0 = 0;
        repeat (4) @(negedge clk);
        // R5: outputs cleared in reset
        check("R5", "u0 out_vld in reset", longint'(ov0), 0);
        check("R5", "u0 product in reset", longint'(pr0), 0);
        check("R5", "u1 product in reset", longint'(pr1), 0);
        check("R5", "u2 product in reset", longint'(pr2), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R5", "u2 out_vld after reset", longint'(ov2), 0);
        check("R5", "u1 product after reset", longint'(pr1), 0);

        for (int c = 0; c < 1200; c++) begin
            // sample outputs driven by the last edge
            if (q0.size() == 3) begin
                e = q0.pop_front();
                compare("u0", "R1", e, ov0, longint'($signed(pr0)), hold0);
            end
            if (q1.size() == 1) begin
                e = q1.pop_front();
                compare("u1", "R6", e, ov1, longint'($signed(pr1)), hold1);
            end
            if (q2.size() == 5) begin
                e = q2.pop_front();
                compare("u2", (c < 10) ? "R7" : "R1", e, ov2, longint'($signed(pr2)), hold2);
            end

            // u0: exhaustive 256 pairs, with idle gaps carrying junk operands (R8)
            v0 = (k0 < 256) && (c % 5 != 3);
            if (v0) begin
                xa0 = k0[7:4];
                yb0 = k0[3:0];
                k0++;
            end else begin
                xa0 = 4'($urandom);
                yb0 = 4'($urandom);
            end

            // u1 and u2: extremes first (R7), then random traffic
            v1 = (c < 4) || ($urandom % 4 != 0);
            v2 = (c < 4) || ($urandom % 3 != 0);
            xa1 = 8'($urandom);
            yb1 = 8'($urandom);
            xa2 = 16'($urandom);
            yb2 = 16'($urandom);
            case (c)
                0: begin xa1 = 8'h80; yb1 = 8'h80; xa2 = 16'h8000; yb2 = 16'h8000; end
                1: begin xa1 = 8'h80; yb1 = 8'h7f; xa2 = 16'h8000; yb2 = 16'h7fff; end
                2: begin xa1 = 8'h7f; yb1 = 8'h7f; xa2 = 16'h7fff; yb2 = 16'h7fff; end
                3: begin xa1 = 8'h00; yb1 = 8'hff; xa2 = 16'hffff; yb2 = 16'hffff; end
                default: ;
            endcase

            e.v = v0; e.p = longint'($signed(xa0)) * longint'($signed(yb0)); q0.push_back(e);
            e.v = v1; e.p = longint'($signed(xa1)) * longint'($signed(yb1)); q1.push_back(e);
            e.v = v2; e.p = longint'($signed(xa2)) * longint'($signed(yb2)); q2.push_back(e);

            @(negedge clk);
        end

        check("R1", "u0 pairs covered", longint'(k0), 256);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule